// File: doc/BRIEF.md
# Parallel Translate-and-Tag Lookup

This block performs one load or store lookup per cycle against a small direct-mapped cache and a fully associative translation buffer at the same time. The line index comes purely from page-offset bits of the virtual address, which are identical before and after translation. That lets the cache read start without waiting for the translation buffer. The stored line tag is a physical page number. It is compared against the page number that the translation buffer returns in the same cycle.

Each accepted request receives one registered response on the following cycle, with exactly one outcome:
- **Hit:** line data is delivered.
- **Memory request:** the line is invalid or its tag disagrees, but the translation is known, so the full physical address is emitted.
- **Translation request:** the translation buffer has no entry for the page, so a page-table walk must be started elsewhere.

Separate ports refill the translation buffer and the cache. A single pulse clears every reference bit, so software can approximate least-recently-used replacement.

The geometry is 4 KB pages (a 20-bit page number above a 12-bit offset) and 1024 word-sized lines. The translation buffer has sixteen entries.

Top module: `vipt_lookup`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every output is zero. No translation entry and no cache line is valid, so a first lookup reports a translation request.
- R2: A request presented with `req_valid` high produces `resp_valid` high exactly one cycle later. A cycle without a request gives `resp_valid` low with every other output zero.
- R3: The line index is `req_vaddr[11:2]`. When that line is valid and its stored tag equals the physical page number from the translation buffer, `resp_cache_hit` is 1 and `resp_data` carries the stored word.
- R4: When the translation buffer hits but the line is invalid or its tag differs, `mem_req` is 1 and `mem_paddr` is {physical page number, `req_vaddr[11:0]`}. In that case `resp_data` is zero.
- R5: When no valid translation entry matches `req_vaddr[31:12]`, `xlate_req` is 1 and `resp_tlb_hit` is 0. No cache hit is reported, whatever the line holds.
- R6: Every response carries exactly one of `resp_cache_hit`, `mem_req` and `xlate_req`.
- R7: Translation refills fill the sixteen slots in round-robin order, starting at slot 0, so the seventeenth distinct page evicts the first. A refill whose virtual page is already present overwrites that entry instead, and the round-robin position does not advance.
- R8: On a translation hit, `resp_pte_dirty` reports the entry's dirty bit as stored before the access. A write hit (`req_write` = 1) sets that bit. A refilled entry starts clean.
- R9: On a translation hit, `resp_pte_ref` reports the entry's reference bit as stored before the access. Any hit sets it. `ref_clear` clears all reference bits, but an entry hit in the same cycle still ends with its bit set.
- R10: A cache fill stores `cache_fill_line[29:10]` as the tag, the word as data, and marks index `cache_fill_line[9:0]` valid. A lookup in the same cycle sees the line's earlier contents.
- R11: A translation refill in the same cycle as a lookup takes effect afterwards. The lookup uses the earlier contents, and the refilled entry's dirty and reference bits start at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_vaddr | input | 32 | Virtual byte address |
| req_write | input | 1 | 1 for a store, 0 for a load |
| tlb_fill_valid | input | 1 | Write a translation entry |
| tlb_fill_vpn | input | 20 | Virtual page number to install |
| tlb_fill_ppn | input | 20 | Physical page number to install |
| ref_clear | input | 1 | Clear all reference bits |
| cache_fill_valid | input | 1 | Write a cache line |
| cache_fill_line | input | 30 | Physical word address of the line (tag above index) |
| cache_fill_data | input | 32 | Word to store |
| resp_valid | output | 1 | Response for last cycle's request |
| resp_cache_hit | output | 1 | Line hit; data valid |
| resp_tlb_hit | output | 1 | Translation found |
| resp_data | output | 32 | Line data on a hit, else zero |
| mem_req | output | 1 | Fetch from memory at `mem_paddr` |
| mem_paddr | output | 32 | Physical byte address on a memory request, else zero |
| xlate_req | output | 1 | Page-table translation needed |
| resp_pte_dirty | output | 1 | Dirty bit of the hit entry before the access |
| resp_pte_ref | output | 1 | Reference bit of the hit entry before the access |

## Verification
Two pairs of functions can land in the same cycle:
- A lookup together with a translation refill or a cache fill for the very page or line being looked up.
- An access together with the global reference clear.

Directed steps set up each collision explicitly. A long random phase draws from a few pages and offsets so that collisions keep recurring. A behavioural model in the bench updates its state only after forming each cycle's expected response. A response that already reflects a same-cycle update shows up as a field mismatch on the next cycle, as does a reference bit that loses to the clear.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

  typedef enum logic [1:0] {
    OUT_NONE  = 2'd0,
    OUT_HIT   = 2'd1,
    OUT_MEM   = 2'd2,
    OUT_XLATE = 2'd3
  } outcome_e;

endpackage

// File: rtl/vipt_tlb_cam.sv
module vipt_tlb_cam #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_en,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_write,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             ref_clr,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn,
  output logic             hit_dirty,
  output logic             hit_ref
);

  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [ENTRIES-1:0] dty_q, dty_d;
  logic [ENTRIES-1:0] ref_q, ref_d;
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];

  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] fl_match;
  logic [ENTRIES-1:0] fill_sel;
  logic               fl_any;

  // Per-entry comparators and payload storage
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign lk_match[e] = lk_en && vld_q[e] && (vpn_q[e] == lk_vpn);
    assign fl_match[e] = vld_q[e] && (vpn_q[e] == fill_vpn);

    always_ff @(posedge clk) begin
      if (fill_en && fill_sel[e]) begin
        vpn_q[e] <= fill_vpn;
        ppn_q[e] <= fill_ppn;
      end
    end
  end

  assign fl_any = |fl_match;

  // Refill steering: an existing copy of the page wins over the round-robin slot
  always_comb begin
    if (fl_any) begin
      fill_sel = fl_match;
    end else begin
      fill_sel = ENTRIES'(1) << ptr_q;
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (fill_en && !fl_any) begin
      if (ptr_q == PTR_W'(ENTRIES - 1)) begin
        ptr_d = '0;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end
  end

  // Lookup read mux
  always_comb begin
    hit       = |lk_match;
    hit_ppn   = '0;
    hit_dirty = 1'b0;
    hit_ref   = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (lk_match[e]) begin
        hit_ppn   = hit_ppn | ppn_q[e];
        hit_dirty = hit_dirty | dty_q[e];
        hit_ref   = hit_ref | ref_q[e];
      end
    end
  end

  // Status bit next state: refill > access > global clear
  always_comb begin
    vld_d = vld_q;
    dty_d = dty_q;
    ref_d = ref_q;
    for (int e = 0; e < ENTRIES; e++) begin
      if (fill_en && fill_sel[e]) begin
        vld_d[e] = 1'b1;
        dty_d[e] = 1'b0;
        ref_d[e] = 1'b0;
      end else begin
        if (ref_clr) begin
          ref_d[e] = 1'b0;
        end
        if (lk_match[e]) begin
          ref_d[e] = 1'b1;
          if (lk_write) begin
            dty_d[e] = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dty_q <= '0;
      ref_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_d;
      dty_q <= dty_d;
      ref_q <= ref_d;
      ptr_q <= ptr_d;
    end
  end

endmodule

// File: rtl/vipt_cache_array.sv
module vipt_cache_array #(
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  line_vld_q, line_vld_d;
  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];

  assign rd_valid = line_vld_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_data  = data_mem[rd_idx];

  always_comb begin
    line_vld_d = line_vld_q;
    if (wr_en) begin
      line_vld_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_vld_q <= '0;
    end else begin
      line_vld_q <= line_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
  end

endmodule

// File: rtl/vipt_decide.sv
module vipt_decide
  import vipt_pkg::*;
#(
  parameter int PPN_W  = 20,
  parameter int OFF_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic                   req_valid,
  input  logic [OFF_W-1:0]       page_off,
  input  logic                   tlb_hit,
  input  logic [PPN_W-1:0]       tlb_ppn,
  input  logic                   tlb_dirty,
  input  logic                   tlb_ref,
  input  logic                   line_valid,
  input  logic [PPN_W-1:0]       line_tag,
  input  logic [DATA_W-1:0]      line_data,
  output outcome_e               outcome,
  output logic [DATA_W-1:0]      data,
  output logic [PPN_W+OFF_W-1:0] paddr,
  output logic                   pte_dirty,
  output logic                   pte_ref
);

  always_comb begin
    outcome   = OUT_NONE;
    data      = '0;
    paddr     = '0;
    pte_dirty = 1'b0;
    pte_ref   = 1'b0;
    if (req_valid) begin
      if (!tlb_hit) begin
        outcome = OUT_XLATE;
      end else begin
        pte_dirty = tlb_dirty;
        pte_ref   = tlb_ref;
        if (line_valid && (line_tag == tlb_ppn)) begin
          outcome = OUT_HIT;
          data    = line_data;
        end else begin
          outcome = OUT_MEM;
          paddr   = {tlb_ppn, page_off};
        end
      end
    end
  end

endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
  import vipt_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int PAGE_W      = 12,
  parameter int WORD_OFF_W  = 2,
  parameter int DATA_W      = 32,
  parameter int TLB_ENTRIES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [VA_W-1:0]            req_vaddr,
  input  logic                       req_write,
  input  logic                       tlb_fill_valid,
  input  logic [VA_W-PAGE_W-1:0]     tlb_fill_vpn,
  input  logic [PA_W-PAGE_W-1:0]     tlb_fill_ppn,
  input  logic                       ref_clear,
  input  logic                       cache_fill_valid,
  input  logic [PA_W-WORD_OFF_W-1:0] cache_fill_line,
  input  logic [DATA_W-1:0]          cache_fill_data,
  output logic                       resp_valid,
  output logic                       resp_cache_hit,
  output logic                       resp_tlb_hit,
  output logic [DATA_W-1:0]          resp_data,
  output logic                       mem_req,
  output logic [PA_W-1:0]            mem_paddr,
  output logic                       xlate_req,
  output logic                       resp_pte_dirty,
  output logic                       resp_pte_ref
);

  localparam int VPN_W = VA_W - PAGE_W;
  localparam int PPN_W = PA_W - PAGE_W;
  localparam int IDX_W = PAGE_W - WORD_OFF_W;

  logic             tlb_hit;
  logic [PPN_W-1:0] tlb_ppn;
  logic             tlb_dirty;
  logic             tlb_ref;
  logic             line_valid;
  logic [PPN_W-1:0] line_tag;
  logic [DATA_W-1:0] line_data;

  outcome_e          outcome_d, outcome_q;
  logic [DATA_W-1:0] data_d, data_q;
  logic [PA_W-1:0]   paddr_d, paddr_q;
  logic              dirty_d, dirty_q;
  logic              ref_d, ref_q;
  logic              rvld_q;

  vipt_tlb_cam #(
    .ENTRIES (TLB_ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W)
  ) u_tlb (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_en     (req_valid),
    .lk_vpn    (req_vaddr[VA_W-1:PAGE_W]),
    .lk_write  (req_write),
    .fill_en   (tlb_fill_valid),
    .fill_vpn  (tlb_fill_vpn),
    .fill_ppn  (tlb_fill_ppn),
    .ref_clr   (ref_clear),
    .hit       (tlb_hit),
    .hit_ppn   (tlb_ppn),
    .hit_dirty (tlb_dirty),
    .hit_ref   (tlb_ref)
  );

  // Index taken only from untranslated offset bits
  vipt_cache_array #(
    .IDX_W  (IDX_W),
    .TAG_W  (PPN_W),
    .DATA_W (DATA_W)
  ) u_cache (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (req_vaddr[PAGE_W-1:WORD_OFF_W]),
    .rd_valid (line_valid),
    .rd_tag   (line_tag),
    .rd_data  (line_data),
    .wr_en    (cache_fill_valid),
    .wr_idx   (cache_fill_line[IDX_W-1:0]),
    .wr_tag   (cache_fill_line[PA_W-WORD_OFF_W-1:IDX_W]),
    .wr_data  (cache_fill_data)
  );

  vipt_decide #(
    .PPN_W  (PPN_W),
    .OFF_W  (PAGE_W),
    .DATA_W (DATA_W)
  ) u_decide (
    .req_valid  (req_valid),
    .page_off   (req_vaddr[PAGE_W-1:0]),
    .tlb_hit    (tlb_hit),
    .tlb_ppn    (tlb_ppn),
    .tlb_dirty  (tlb_dirty),
    .tlb_ref    (tlb_ref),
    .line_valid (line_valid),
    .line_tag   (line_tag),
    .line_data  (line_data),
    .outcome    (outcome_d),
    .data       (data_d),
    .paddr      (paddr_d),
    .pte_dirty  (dirty_d),
    .pte_ref    (ref_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvld_q    <= 1'b0;
      outcome_q <= OUT_NONE;
      data_q    <= '0;
      paddr_q   <= '0;
      dirty_q   <= 1'b0;
      ref_q     <= 1'b0;
    end else begin
      rvld_q    <= req_valid;
      outcome_q <= outcome_d;
      data_q    <= data_d;
      paddr_q   <= paddr_d;
      dirty_q   <= dirty_d;
      ref_q     <= ref_d;
    end
  end

  assign resp_valid     = rvld_q;
  assign resp_cache_hit = (outcome_q == OUT_HIT);
  assign mem_req        = (outcome_q == OUT_MEM);
  assign xlate_req      = (outcome_q == OUT_XLATE);
  assign resp_tlb_hit   = resp_cache_hit || mem_req;
  assign resp_data      = data_q;
  assign mem_paddr      = paddr_q;
  assign resp_pte_dirty = dirty_q;
  assign resp_pte_ref   = ref_q;

endmodule

// File: rtl/vipt_lookup_chk.sv
module vipt_lookup_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_vaddr,
  input logic        resp_valid,
  input logic        resp_cache_hit,
  input logic        resp_tlb_hit,
  input logic [31:0] resp_data,
  input logic        mem_req,
  input logic [31:0] mem_paddr,
  input logic        xlate_req,
  input logic        resp_pte_dirty,
  input logic        resp_pte_ref
);

  AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid); // R2

  AST_NO_RESP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> (!resp_cache_hit && !mem_req && !xlate_req && resp_data == '0
                     && mem_paddr == '0 && !resp_pte_dirty && !resp_pte_ref)); // R2

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($countones({resp_cache_hit, mem_req, xlate_req}) == 1)); // R6

  AST_HIT_NEEDS_XLATION: assert property (@(posedge clk) disable iff (!rst_n)
    resp_cache_hit |-> resp_tlb_hit); // R3

  AST_WALK_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    xlate_req |-> (!resp_tlb_hit && !resp_pte_dirty && !resp_pte_ref)); // R5

  AST_PADDR_KEEPS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!mem_req || mem_paddr[11:0] == $past(req_vaddr[11:0]))); // R4

  AST_MISS_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (resp_data == '0)); // R4

endmodule

bind vipt_lookup vipt_lookup_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_vaddr      (req_vaddr),
  .resp_valid     (resp_valid),
  .resp_cache_hit (resp_cache_hit),
  .resp_tlb_hit   (resp_tlb_hit),
  .resp_data      (resp_data),
  .mem_req        (mem_req),
  .mem_paddr      (mem_paddr),
  .xlate_req      (xlate_req),
  .resp_pte_dirty (resp_pte_dirty),
  .resp_pte_ref   (resp_pte_ref)
);

// File: tb/sim_vipt_lookup.sv
module sim_vipt_lookup;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic        req_write;
  logic        tlb_fill_valid;
  logic [19:0] tlb_fill_vpn;
  logic [19:0] tlb_fill_ppn;
  logic        ref_clear;
  logic        cache_fill_valid;
  logic [29:0] cache_fill_line;
  logic [31:0] cache_fill_data;
  logic        resp_valid, resp_cache_hit, resp_tlb_hit, mem_req, xlate_req;
  logic        resp_pte_dirty, resp_pte_ref;
  logic [31:0] resp_data, mem_paddr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  vipt_lookup u0 (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural reference state
  bit          m_v   [16];
  logic [19:0] m_vpn [16];
  logic [19:0] m_ppn [16];
  bit          m_d   [16];
  bit          m_r   [16];
  int          m_ptr;
  bit          c_v   [int];
  logic [19:0] c_tag [int];
  logic [31:0] c_dat [int];

  // Expected outputs for the response currently on the ports
  bit          e_valid, e_chit, e_thit, e_mem, e_xl, e_dirty, e_ref;
  logic [31:0] e_data, e_paddr;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycles, act, exp);
    end
  endtask

  task automatic compare();
    chk(resp_valid == e_valid, "R2 resp_valid", 32'(resp_valid), 32'(e_valid));
    chk(resp_cache_hit == e_chit, "R3 cache_hit", 32'(resp_cache_hit), 32'(e_chit));
    chk(resp_data == e_data, "R3 data", resp_data, e_data);
    chk(mem_req == e_mem, "R4 mem_req", 32'(mem_req), 32'(e_mem));
    chk(mem_paddr == e_paddr, "R4 mem_paddr", mem_paddr, e_paddr);
    chk(xlate_req == e_xl, "R5 xlate_req", 32'(xlate_req), 32'(e_xl));
    chk(resp_tlb_hit == e_thit, "R7 tlb_hit", 32'(resp_tlb_hit), 32'(e_thit));
    chk(resp_pte_dirty == e_dirty, "R8 dirty", 32'(resp_pte_dirty), 32'(e_dirty));
    chk(resp_pte_ref == e_ref, "R9 ref", 32'(resp_pte_ref), 32'(e_ref));
    if (resp_valid)
      chk((32'(resp_cache_hit) + 32'(mem_req) + 32'(xlate_req)) == 1, "R6 one outcome",
          {29'd0, resp_cache_hit, mem_req, xlate_req}, 32'd1);
  endtask

  task automatic step(input bit rv, input logic [31:0] va, input bit wr,
                      input bit tf, input logic [19:0] tvpn, input logic [19:0] tppn,
                      input bit rc, input bit cf, input logic [29:0] cline, input logic [31:0] cdat);
    int hi;
    int fi;
    int idx;
    @(negedge clk);
    compare();
    req_valid = rv; req_vaddr = va; req_write = wr;
    tlb_fill_valid = tf; tlb_fill_vpn = tvpn; tlb_fill_ppn = tppn;
    ref_clear = rc;
    cache_fill_valid = cf; cache_fill_line = cline; cache_fill_data = cdat;
    // expected response, formed from state before this edge
    e_valid = rv; e_chit = 0; e_thit = 0; e_mem = 0; e_xl = 0;
    e_dirty = 0; e_ref = 0; e_data = 0; e_paddr = 0;
    hi = -1;
    if (rv) begin
      for (int i = 0; i < 16; i++) if (m_v[i] && m_vpn[i] == va[31:12]) hi = i;
      if (hi < 0) e_xl = 1;
      else begin
        e_thit = 1; e_dirty = m_d[hi]; e_ref = m_r[hi];
        idx = int'(va[11:2]);
        if (c_v.exists(idx) && c_tag[idx] == m_ppn[hi]) begin
          e_chit = 1; e_data = c_dat[idx];
        end else begin
          e_mem = 1; e_paddr = {m_ppn[hi], va[11:0]};
        end
      end
    end
    // state updates
    fi = -1;
    if (tf) begin
      for (int i = 0; i < 16; i++) if (m_v[i] && m_vpn[i] == tvpn) fi = i;
      if (fi < 0) begin fi = m_ptr; m_ptr = (m_ptr + 1) % 16; end
    end
    for (int i = 0; i < 16; i++) begin
      if (i == fi) begin
        m_v[i] = 1; m_vpn[i] = tvpn; m_ppn[i] = tppn; m_d[i] = 0; m_r[i] = 0;
      end else begin
        if (rc) m_r[i] = 0;
        if (i == hi) begin m_r[i] = 1; if (wr) m_d[i] = 1; end
      end
    end
    if (cf) begin
      idx = int'(cline[9:0]);
      c_v[idx] = 1; c_tag[idx] = cline[29:10]; c_dat[idx] = cdat;
    end
  endtask

  task automatic look(input logic [31:0] va, input bit wr);
    step(1, va, wr, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic tfill(input logic [19:0] vpn, input logic [19:0] ppn);
    step(0, 0, 0, 1, vpn, ppn, 0, 0, 0, 0);
  endtask

  task automatic cfill(input logic [31:0] pa, input logic [31:0] d);
    step(0, 0, 0, 0, 0, 0, 0, 1, pa[31:2], d);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    while (cycles < 150000) @(posedge clk) cycles++;
    errors++;
    $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [19:0] pool [8];
    req_valid = 0; req_vaddr = 0; req_write = 0;
    tlb_fill_valid = 0; tlb_fill_vpn = 0; tlb_fill_ppn = 0; ref_clear = 0;
    cache_fill_valid = 0; cache_fill_line = 0; cache_fill_data = 0;
    m_ptr = 0;
    for (int i = 0; i < 16; i++) begin m_v[i] = 0; m_d[i] = 0; m_r[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; end
    e_valid = 0; e_chit = 0; e_thit = 0; e_mem = 0; e_xl = 0; e_dirty = 0; e_ref = 0; e_data = 0; e_paddr = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet during reset
    chk({resp_valid, resp_cache_hit, resp_tlb_hit, mem_req, xlate_req, resp_pte_dirty, resp_pte_ref} == 7'd0
        && resp_data == 0 && mem_paddr == 0, "R1 reset outputs", resp_data | mem_paddr, 32'd0);
    rst_n = 1;
    // R1: first lookup after reset finds nothing
    look(32'h1234_5678, 0);
    idle();
    // R4: translation present, line empty
    tfill(20'h12345, 20'hABCDE);
    look(32'h1234_5678, 0);
    // R3: line filled with matching physical tag
    cfill(32'hABCD_E678, 32'hDEAD_BEEF);
    look(32'h1234_5678, 0);
    look(32'h1234_567B, 0);
    // R4: same index, another page mapping elsewhere -> tag mismatch
    tfill(20'h55555, 20'h0F0F0);
    look(32'h5555_5678, 0);
    // R5: unknown page on a valid line still walks
    look(32'h7777_7678, 0);
    // R8: write hit sets dirty, visible on the next hit
    look(32'h1234_5000, 1);
    look(32'h1234_5000, 0);
    // R9: clear alone, then clear together with an access
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    look(32'h1234_5000, 0);
    step(1, 32'h5555_5000, 0, 0, 0, 0, 1, 0, 0, 0);
    look(32'h5555_5000, 0);
    look(32'h1234_5000, 0);
    // R7: overwrite of a present page keeps the round-robin slot
    tfill(20'h55555, 20'h00111);
    look(32'h5555_5004, 0);
    // R7: fourteen more pages fill slots 2..15, the next one evicts slot 0
    for (int i = 0; i < 15; i++) tfill(20'h80000 + 20'(i), 20'h40000 + 20'(i));
    look(32'h1234_5678, 0);
    look(32'h8000_0000, 0);
    look(32'h8000_E000, 0);
    // R11: refill of the very page being looked up, same cycle
    step(1, 32'h8000_1010, 1, 1, 20'h80001, 20'h22222, 0, 0, 0, 0);
    look(32'h8000_1010, 0);
    // R10: line fill and lookup of that line in the same cycle
    step(1, 32'h8000_1010, 0, 0, 0, 0, 0, 1, {20'h22222, 10'h004}, 32'hCAFE_0001);
    look(32'h8000_1010, 0);
    // Random phase with a small page and offset pool
    for (int i = 0; i < 8; i++) pool[i] = 20'h30000 + 20'(i * 3);
    for (int n = 0; n < 4000; n++) begin
      int pv, pp;
      logic [11:0] off;
      pv = int'($urandom_range(0, 7));
      pp = int'($urandom_range(0, 7));
      off = {6'd0, 4'($urandom_range(0, 15)), 2'($urandom_range(0, 3))};
      step($urandom_range(0, 3) != 0, {pool[pv], off}, $urandom_range(0, 1) == 1,
           $urandom_range(0, 5) == 0, pool[pp], 20'h60000 + 20'($urandom_range(0, 7)),
           $urandom_range(0, 9) == 0,
           $urandom_range(0, 3) == 0, {20'h60000 + 20'($urandom_range(0, 7)), 6'd0, off[5:2]},
           $urandom);
    end
    idle();
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule